// File: doc/BRIEF.md
# Four-Channel Bus Switch Selection Slave

This block is the control side of a four-way two-wire bus switch. It watches the upstream clock and data lines through a deglitching front end that runs on a fast system clock. It recognises START and STOP conditions and answers when its 7-bit address appears on the bus. That address is a fixed five-bit prefix followed by two strap inputs. A write transaction loads a selection byte, and the block drives four channel-enable outputs from it. The enable outputs feed an external pass-gate model.

A written selection waits in a pending register and reaches the enable outputs only when the next STOP is seen. A repeated START in between keeps it pending. Reset before that STOP throws it away. A read transaction returns one status byte. The live interrupt state of the four channels sits in the upper nibble and the committed selection in the lower nibble. The open-drain data driver is modelled as a pull-low enable.

Top module: `i2c_chsel_switch`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 1,1,1,0,0,strap[1],strap[0], sent MSB first. Bit 0 of the address byte selects read (1) or write (0). Any other address gets no acknowledge, and the slave stays silent until the next START or STOP.
- R2: After a matching write address, every data byte is acknowledged, and only the last byte of the transaction is kept.
- R3: Bit k of the kept byte (k = 0..3) enables channel k on chan_en[k]. Any combination may be enabled at once.
- R4: chan_en changes only when a STOP condition is detected, and it then takes the pending selection.
- R5: A read returns one byte, MSB first. Bit 4+k is 1 when irq_n[k] is low, and bits 3:0 are the committed selection.
- R6: Bits 7:4 of a written byte have no effect on chan_en or on the value read back.
- R7: Driving either ext_rst_n or por_n low clears chan_en to 0, releases SDA and returns the bus logic to idle. A pending selection that has not been committed is discarded.
- R8: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts address reception and does not commit a pending selection.
- R9: A pulse on SCL or SDA shorter than FILT_CYC system clocks is rejected and does not disturb a transfer.
- R10: When the master does not acknowledge a read byte, the slave releases SDA and waits for STOP or START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus bit rate |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| scl_in | input | 1 | Upstream bus clock line level |
| sda_in | input | 1 | Upstream bus data line level |
| strap | input | 2 | Address strap pins, lowest two address bits |
| irq_n | input | 4 | Active-low interrupt request, one per channel |
| sda_oe | output | 1 | 1 pulls the data line low |
| chan_en | output | 4 | Committed channel enables, bit k for channel k |

## Verification
A wrong bit count or a wrong state in the engine shows on the bus within one byte time. The acknowledge then appears on the wrong clock pulse, or does not appear at all, so the master sees a missing or extra acknowledge at the ninth pulse. A corrupted pending register or a wrong commit condition does not show until the STOP that follows. It then appears at once as a wrong chan_en, or before the STOP as an early change of chan_en. A wrong pack order of the status byte shows on the first read after the interrupt lines change.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_AACK = 3'd2,
      ST_WR   = 3'd3,
      ST_WACK = 3'd4,
      ST_RD   = 3'd5,
      ST_RACK = 3'd6,
      ST_SKIP = 3'd7
   } state_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/bus_deglitch.sv
module bus_deglitch #(
   parameter int CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

   logic       s0, s1;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s0   <= 1'b1;
         s1   <= 1'b1;
         dout <= 1'b1;
         cnt  <= '0;
      end else begin
         s0 <= din;
         s1 <= s0;
         if (s1 != dout) begin
            if (cnt == CW'(CYC - 1)) begin
               dout <= s1;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/bus_event_det.sv
module bus_event_det (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic ev_start,
   output logic ev_stop,
   output logic ev_rise,
   output logic ev_fall
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   always_comb begin
      ev_start = scl & scl_q & sda_q & ~sda;
      ev_stop  = scl & scl_q & ~sda_q & sda;
      ev_rise  = scl & ~scl_q;
      ev_fall  = ~scl & scl_q;
   end
endmodule

// File: rtl/chsel_engine.sv
module chsel_engine
   import chsel_pkg::*;
#(
   parameter int         NCH     = 4,
   parameter logic [4:0] ADDR_HI = 5'b11100
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sda,
   input  logic           ev_start,
   input  logic           ev_stop,
   input  logic           ev_rise,
   input  logic           ev_fall,
   input  logic [1:0]     strap,
   input  logic [NCH-1:0] irq_act,
   output logic           pull,
   output logic [NCH-1:0] chan,
   output state_e         st
);
   localparam int CNTW = $clog2(BYTE_W + 1);

   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] tx;
   logic [CNTW-1:0]   cnt;
   logic [NCH-1:0]    pend;
   logic              pend_v;
   logic              rw;
   logic              more;
   logic [BYTE_W-1:0] status;

   assign status = {irq_act, chan};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         sh     <= '0;
         tx     <= '0;
         cnt    <= '0;
         pend   <= '0;
         pend_v <= 1'b0;
         rw     <= 1'b0;
         more   <= 1'b0;
         pull   <= 1'b0;
         chan   <= '0;
      end else if (ev_start) begin
         st   <= ST_ADDR;
         cnt  <= '0;
         pull <= 1'b0;
      end else if (ev_stop) begin
         st     <= ST_IDLE;
         pull   <= 1'b0;
         pend_v <= 1'b0;
         if (pend_v) chan <= pend;
      end else begin
         unique case (st)
            ST_ADDR, ST_WR: begin
               if (ev_rise) begin
                  sh  <= {sh[BYTE_W-2:0], sda};
                  cnt <= cnt + 1'b1;
               end else if (ev_fall && cnt == CNTW'(BYTE_W)) begin
                  if (st == ST_WR) begin
                     pend   <= sh[NCH-1:0];
                     pend_v <= 1'b1;
                     pull   <= 1'b1;
                     st     <= ST_WACK;
                  end else if (sh[7:1] == {ADDR_HI, strap}) begin
                     rw   <= sh[0];
                     pull <= 1'b1;
                     st   <= ST_AACK;
                  end else begin
                     st <= ST_SKIP;
                  end
               end
            end
            ST_AACK, ST_WACK: begin
               if (ev_fall) begin
                  cnt <= '0;
                  if (st == ST_AACK && rw) begin
                     tx   <= status;
                     pull <= ~status[BYTE_W-1];
                     st   <= ST_RD;
                  end else begin
                     pull <= 1'b0;
                     st   <= ST_WR;
                  end
               end
            end
            ST_RD: begin
               if (ev_rise) begin
                  cnt <= cnt + 1'b1;
               end else if (ev_fall) begin
                  if (cnt == CNTW'(BYTE_W)) begin
                     pull <= 1'b0;
                     st   <= ST_RACK;
                  end else begin
                     tx   <= {tx[BYTE_W-2:0], 1'b0};
                     pull <= ~tx[BYTE_W-2];
                  end
               end
            end
            ST_RACK: begin
               if (ev_rise) begin
                  more <= ~sda;
               end else if (ev_fall) begin
                  cnt <= '0;
                  if (more) begin
                     tx   <= status;
                     pull <= ~status[BYTE_W-1];
                     st   <= ST_RD;
                  end else begin
                     st <= ST_SKIP;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_chsel_switch.sv
module i2c_chsel_switch
   import chsel_pkg::*;
#(
   parameter int         NCH      = 4,
   parameter int         FILT_CYC = 5,
   parameter logic [4:0] ADDR_HI  = 5'b11100
) (
   input  logic           clk,
   input  logic           por_n,
   input  logic           ext_rst_n,
   input  logic           scl_in,
   input  logic           sda_in,
   input  logic [1:0]     strap,
   input  logic [NCH-1:0] irq_n,
   output logic           sda_oe,
   output logic [NCH-1:0] chan_en
);
   localparam int NLINE = 2;

   if (NCH * 2 != BYTE_W) begin : g_bad_nch
      $error("NCH must fill half of the status byte");
   end
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("FILT_CYC must be at least 1");
   end

   logic             rst_n_i;
   logic [NLINE-1:0] raw_ln, flt_ln;
   logic             ev_start, ev_stop, ev_rise, ev_fall;
   logic [NCH-1:0]   irq_s0, irq_s1;
   state_e           eng_st;

   assign rst_n_i = por_n & ext_rst_n;
   assign raw_ln  = {sda_in, scl_in};

   for (genvar i = 0; i < NLINE; i++) begin : g_line
      bus_deglitch #(.CYC(FILT_CYC)) u_flt (
         .clk  (clk),
         .rst_n(rst_n_i),
         .din  (raw_ln[i]),
         .dout (flt_ln[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i) begin
         irq_s0 <= '1;
         irq_s1 <= '1;
      end else begin
         irq_s0 <= irq_n;
         irq_s1 <= irq_s0;
      end
   end

   bus_event_det u_det (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .scl     (flt_ln[0]),
      .sda     (flt_ln[1]),
      .ev_start(ev_start),
      .ev_stop (ev_stop),
      .ev_rise (ev_rise),
      .ev_fall (ev_fall)
   );

   chsel_engine #(.NCH(NCH), .ADDR_HI(ADDR_HI)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .sda     (flt_ln[1]),
      .ev_start(ev_start),
      .ev_stop (ev_stop),
      .ev_rise (ev_rise),
      .ev_fall (ev_fall),
      .strap   (strap),
      .irq_act (~irq_s1),
      .pull    (sda_oe),
      .chan    (chan_en),
      .st      (eng_st)
   );
endmodule

// File: rtl/chsel_checker.sv
module chsel_checker
   import chsel_pkg::*;
#(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           sda_oe,
   input logic [NCH-1:0] chan_en,
   input logic           ev_start,
   input logic           ev_stop,
   input state_e         st
);
   // R4
   chan_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(chan_en) |-> $past(ev_stop));

   // R7
   rst_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (chan_en == '0 && !sda_oe));

   // R8
   start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start |=> (st == ST_ADDR && !sda_oe));

   // R8
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> (st == ST_IDLE && !sda_oe));

   // R8
   event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_start, ev_stop}));

   // R10
   drive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (st == ST_AACK || st == ST_WACK || st == ST_RD));
endmodule

bind i2c_chsel_switch chsel_checker #(.NCH(NCH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n_i),
   .sda_oe  (sda_oe),
   .chan_en (chan_en),
   .ev_start(ev_start),
   .ev_stop (ev_stop),
   .st      (eng_st)
);

// File: tb/sim_i2c_chsel_switch.sv
`timescale 1ns/1ps
module sim_i2c_chsel_switch;
   localparam int Q = 12;
   localparam logic [1:0] STRAP = 2'b10;

   logic clk = 1'b0;
   logic por_n = 1'b1, ext_rst_n = 1'b1;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [3:0] irq_n = 4'hF;
   logic sda_oe;
   logic [3:0] chan_en;
   logic sda_bus;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   i2c_chsel_switch u0 (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
      .scl_in(scl_m), .sda_in(sda_bus), .strap(STRAP),
      .irq_n(irq_n), .sda_oe(sda_oe), .chan_en(chan_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      if (!scl_m) begin
         sda_m = 1'b1; tick(Q);
         scl_m = 1'b1; tick(2*Q);
      end else begin
         sda_m = 1'b1; tick(Q);
      end
      sda_m = 1'b0; tick(2*Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(3*Q);
   endtask

   task automatic send_bit(input logic b, input bit glitch);
      sda_m = b; tick(Q);
      scl_m = 1'b1;
      if (glitch) begin
         tick(6); scl_m = 1'b0; tick(2); scl_m = 1'b1;
         tick(6); sda_m = ~b;   tick(2); sda_m = b; tick(8);
      end else begin
         tick(2*Q);
      end
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_bit(output logic r);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      r = sda_bus; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, input bit glitch, output bit ack);
      logic r;
      for (int i = 7; i >= 0; i--) send_bit(b[i], glitch);
      recv_bit(r);
      ack = !r;
   endtask

   task automatic rd_byte(output logic [7:0] d, input bit nack);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(r);
         d[i] = r;
      end
      send_bit(nack, 1'b0);
   endtask

   function automatic logic [7:0] addr_byte(input bit rd);
      return {5'b11100, STRAP, rd};
   endfunction

   task automatic write_sel(input logic [7:0] v, output bit a0, output bit a1);
      bus_start;
      wr_byte(addr_byte(1'b0), 1'b0, a0);
      wr_byte(v, 1'b0, a1);
   endtask

   task automatic read_stat(output logic [7:0] d, output bit a0);
      bus_start;
      wr_byte(addr_byte(1'b1), 1'b0, a0);
      rd_byte(d, 1'b1);
   endtask

   initial begin
      bit a0, a1, a2;
      logic [7:0] d;
      #1 por_n = 1'b0; ext_rst_n = 1'b0;
      tick(4);
      // R7 reset state
      chk(chan_en == 4'h0 && !sda_oe, "R7 reset", chan_en, 0);
      por_n = 1'b1; ext_rst_n = 1'b1;
      tick(10);

      // R1 address sweep over every 7-bit address
      for (int a = 0; a < 128; a++) begin
         bit exp_ack;
         bus_start;
         wr_byte({a[6:0], 1'b0}, 1'b0, a0);
         bus_stop;
         exp_ack = (a[6:2] == 5'b11100) && (a[1:0] == STRAP);
         chk(a0 == exp_ack, "R1 address", a0, exp_ack);
      end
      chk(chan_en == 4'h0, "R1 no write", chan_en, 0);

      // R3 R4 R6 every selection value, with junk in the upper nibble
      for (int v = 0; v < 16; v++) begin
         logic [3:0] prev;
         logic [7:0] wb;
         prev = chan_en;
         wb = {4'(v * 7 + 3), 4'(v)};
         write_sel(wb, a0, a1);
         chk(a0 && a1, "R2 ack", {a0, a1}, 3);
         chk(chan_en == prev, "R4 held before STOP", chan_en, prev);
         bus_stop;
         chk(chan_en == 4'(v), "R3 R6 commit", chan_en, v);
      end

      // R2 several bytes, last one kept
      bus_start;
      wr_byte(addr_byte(1'b0), 1'b0, a0);
      wr_byte(8'h01, 1'b0, a1);
      wr_byte(8'h02, 1'b0, a2);
      chk(a1 && a2, "R2 ack each", {a1, a2}, 3);
      wr_byte(8'h3A, 1'b0, a2);
      bus_stop;
      chk(chan_en == 4'hA, "R2 last byte", chan_en, 4'hA);

      // R5 status byte for every interrupt pattern
      for (int p = 0; p < 16; p++) begin
         irq_n = 4'(p);
         tick(4);
         read_stat(d, a0);
         // R10 released after NACK
         tick(Q);
         chk(!sda_oe, "R10 release", sda_oe, 0);
         bus_stop;
         chk(d == {~4'(p), 4'hA}, "R5 read", d, {~4'(p), 4'hA});
      end
      irq_n = 4'hF;

      // R6 upper nibble of written byte not readable
      write_sel(8'hF5, a0, a1);
      bus_stop;
      tick(4);
      read_stat(d, a0);
      bus_stop;
      chk(d == 8'h05, "R6 read back", d, 8'h05);

      // R8 repeated START keeps selection pending
      write_sel(8'h0C, a0, a1);
      bus_start;
      wr_byte(addr_byte(1'b1), 1'b0, a0);
      rd_byte(d, 1'b1);
      chk(a0 && d == 8'h05, "R8 repeated start read", d, 8'h05);
      chk(chan_en == 4'h5, "R8 no commit on Sr", chan_en, 5);
      bus_stop;
      chk(chan_en == 4'hC, "R8 commit at STOP", chan_en, 4'hC);

      // R9 glitches on both lines during every bit
      bus_start;
      wr_byte(addr_byte(1'b0), 1'b1, a0);
      wr_byte(8'h06, 1'b1, a1);
      bus_stop;
      chk(a0 && a1, "R9 ack with glitches", {a0, a1}, 3);
      chk(chan_en == 4'h6, "R9 filtered data", chan_en, 6);

      // R7 pending discarded by external reset
      write_sel(8'h0F, a0, a1);
      ext_rst_n = 1'b0; tick(3); ext_rst_n = 1'b1; tick(3);
      chk(chan_en == 4'h0, "R7 ext reset", chan_en, 0);
      bus_stop;
      chk(chan_en == 4'h0, "R7 pending discarded", chan_en, 0);

      // R7 power-on reset
      write_sel(8'h09, a0, a1);
      bus_stop;
      chk(chan_en == 4'h9, "R3 before por", chan_en, 9);
      por_n = 1'b0; tick(3);
      chk(chan_en == 4'h0 && !sda_oe, "R7 por", chan_en, 0);
      por_n = 1'b1; tick(10);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule